// File: doc/BRIEF.md
# Daisy-Chain Register Frame Forwarder

This block sits in each device of a serial daisy chain and steers 11-byte register frames. A request arrives from upstream as a byte stream. A flag marks the header byte, which always comes first. A 4-bit hop count sits in header bits [7:4]. A hop count of 1 means the frame is meant for this device, and the whole frame goes to the local register processor unchanged. Any other hop count sends the frame on downstream. A hop count of 2 or more is lowered by one on the way out. A hop count of 0 passes through untouched. The chain can hold up to 15 devices.

On the return path, responses come either from the downstream neighbour or from the local processor. They are merged onto one upstream byte stream. As each response passes, the footer byte (byte 9) is ORed with this stage's error flags, so the footer the host receives is the OR over all stages. Whenever a byte changes, the checksum byte (byte 10) is adjusted by the same amount as the change in the byte sum. The checksum is the bitwise NOT of the modulo-256 sum of bytes 0 to 9. A frame that was valid stays valid, and a corrupted frame stays corrupted by the same amount.

Only one transaction is in flight at a time, so there is no backpressure at any edge. Line coding and serialization happen outside this block.

Top module: `chain_frame_forwarder`

## Requirements
- R1: A request whose header hop field (bits [7:4] of byte 0) equals 1 is delivered byte for byte, unmodified, on the local request output, and no byte of it appears downstream.
- R2: A request whose hop field is 2 to 15 is delivered on the downstream request output with the hop field lowered by one. Header bits [3:0] and bytes 1 to 9 are unchanged.
- R3: A request whose hop field is 0 is delivered downstream with all 11 bytes unchanged, including the checksum.
- R4: The checksum byte (byte 10) leaving either path equals the incoming checksum plus (incoming sum of bytes 0-9 minus outgoing sum of bytes 0-9), modulo 256. A consistent frame therefore stays consistent, and a bad checksum keeps its error.
- R5: Every accepted byte appears on its output exactly one clock after it is presented. Idle cycles (valid low) may separate the bytes of a frame, and the first-byte flag travels with the header.
- R6: A byte presented with valid high and the first flag low, when no frame is open (11 bytes already taken, or since reset), is dropped and produces no output.
- R7: A first-flagged byte that arrives in the middle of a frame starts a new frame. Its header sets the new route, and the bytes already sent are not recalled.
- R8: On a response, byte 9 leaving upstream equals the incoming footer ORed with `stage_flags`, sampled in the cycle the footer byte is presented. The checksum is adjusted as in R4, and the other bytes are unchanged.
- R9: Responses from the downstream input and from the local input are both forwarded upstream with the same footer and checksum treatment. If both inputs present a byte in the same cycle, the local byte is taken.
- R10: During and right after a synchronous active-low reset, all three output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_req_valid | input | 1 | Request byte from upstream is present |
| up_req_first | input | 1 | Request byte is the header (byte 0) |
| up_req_data | input | 8 | Request byte |
| loc_req_valid | output | 1 | Request byte for the local register processor |
| loc_req_first | output | 1 | Local request byte is the header |
| loc_req_data | output | 8 | Local request byte |
| dn_req_valid | output | 1 | Request byte to the downstream device |
| dn_req_first | output | 1 | Downstream request byte is the header |
| dn_req_data | output | 8 | Downstream request byte |
| dn_rsp_valid | input | 1 | Response byte from downstream is present |
| dn_rsp_first | input | 1 | Downstream response byte is the header |
| dn_rsp_data | input | 8 | Downstream response byte |
| loc_rsp_valid | input | 1 | Response byte from local processor is present |
| loc_rsp_first | input | 1 | Local response byte is the header |
| loc_rsp_data | input | 8 | Local response byte |
| stage_flags | input | 8 | This stage's error bits, ORed into response footers |
| up_rsp_valid | output | 1 | Response byte to upstream |
| up_rsp_first | output | 1 | Upstream response byte is the header |
| up_rsp_data | output | 8 | Upstream response byte |

## Verification
The assertions assume that a header byte always carries the first flag. They also assume that the downstream and local response inputs never present bytes at the same time, which holds because only one transaction is outstanding. The bench therefore sends requests and responses one frame at a time, never overlaps the two response sources, and holds `stage_flags` steady for the whole response that samples it. Irregular timing is exercised only through idle gaps between bytes, stray bytes outside a frame, and a frame cut short by a new header.

// File: rtl/chain_fwd_pkg.sv
// Shared constants and types for the daisy-chain frame forwarder.
// Assumes the header is always byte 0, the footer sits just before the
// checksum, and the checksum is the last byte of the frame.
package chain_fwd_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 11;
    localparam int HOP_LO      = 4;
    localparam int HOP_W       = 4;
    localparam int LOCAL_HOP   = 1;

    typedef enum logic {
        DEST_DOWN  = 1'b0,
        DEST_LOCAL = 1'b1
    } dest_e;
endpackage

// File: rtl/chain_frame_tracker.sv
// Tracks the byte position inside an incoming frame.
// A first-flagged byte always restarts at position 0; an unflagged byte is
// accepted only while fewer than FRAME_LEN bytes have been taken.
// Assumes valid and first are meaningful only together (first implies valid).
module chain_frame_tracker #(
    parameter int FRAME_LEN = 11,
    parameter int POS_W     = $clog2(FRAME_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_first,
    output logic [POS_W-1:0] pos,
    output logic             accept
);
    logic [POS_W-1:0] pos_q;

    // Current byte position and acceptance decision.
    always_comb begin
        pos    = beat_first ? '0 : pos_q;
        accept = beat_valid && (beat_first || (pos_q < POS_W'(FRAME_LEN)));
    end

    // Advance the position on every accepted byte; idle means "frame closed".
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_W'(FRAME_LEN);
        end else if (accept) begin
            pos_q <= POS_W'(pos + 1'b1);
        end
    end
endmodule

// File: rtl/chain_req_router.sv
// Request path: picks the destination from the hop field of the header,
// lowers a hop count of two or more by one, and corrects the checksum byte
// by the change made to the header. One register stage, no buffering.
// Assumes the header is the first byte and FRAME_LEN is at least 2.
module chain_req_router import chain_fwd_pkg::*; #(
    parameter int BYTE_W    = chain_fwd_pkg::BYTE_W,
    parameter int FRAME_LEN = chain_fwd_pkg::FRAME_BYTES,
    parameter int HOP_LO    = chain_fwd_pkg::HOP_LO,
    parameter int HOP_W     = chain_fwd_pkg::HOP_W,
    parameter int LOCAL_HOP = chain_fwd_pkg::LOCAL_HOP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [BYTE_W-1:0] in_data,
    output logic              loc_valid,
    output logic              loc_first,
    output logic [BYTE_W-1:0] loc_data,
    output logic              dn_valid,
    output logic              dn_first,
    output logic [BYTE_W-1:0] dn_data
);
    localparam int POS_W    = $clog2(FRAME_LEN + 1);
    localparam int CSUM_POS = FRAME_LEN - 1;
    localparam logic [BYTE_W-1:0] HOP_ONE = BYTE_W'(1) << HOP_LO;

    logic [POS_W-1:0]  pos;
    logic              accept;
    logic [HOP_W-1:0]  hop;
    logic              hdr_local;
    logic              is_hdr;
    dest_e             dest_now;
    dest_e             dest_q;
    logic [BYTE_W-1:0] byte_out;
    logic [BYTE_W-1:0] adj_q;
    logic [BYTE_W-1:0] data_q;
    logic              first_q;
    logic              loc_v_q;
    logic              dn_v_q;

    chain_frame_tracker #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (in_valid),
        .beat_first (in_first),
        .pos        (pos),
        .accept     (accept)
    );

    // Destination choice and per-byte rewrite of header and checksum.
    always_comb begin
        hop       = in_data[HOP_LO +: HOP_W];
        is_hdr    = (pos == '0);
        hdr_local = (hop == HOP_W'(LOCAL_HOP));
        dest_now  = is_hdr ? (hdr_local ? DEST_LOCAL : DEST_DOWN) : dest_q;
        byte_out  = in_data;
        if (is_hdr && !hdr_local && (hop != '0)) begin
            byte_out = in_data - HOP_ONE;
        end else if (pos == POS_W'(CSUM_POS)) begin
            byte_out = in_data + adj_q;
        end
    end

    // Latch the route and the checksum correction when the header is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q <= DEST_DOWN;
            adj_q  <= '0;
        end else if (accept && is_hdr) begin
            dest_q <= dest_now;
            adj_q  <= in_data - byte_out;
        end
    end

    // Output register stage shared by both request destinations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_v_q <= 1'b0;
            dn_v_q  <= 1'b0;
            first_q <= 1'b0;
            data_q  <= '0;
        end else begin
            loc_v_q <= accept && (dest_now == DEST_LOCAL);
            dn_v_q  <= accept && (dest_now == DEST_DOWN);
            first_q <= accept && in_first;
            data_q  <= byte_out;
        end
    end

    assign loc_valid = loc_v_q;
    assign loc_first = first_q;
    assign loc_data  = data_q;
    assign dn_valid  = dn_v_q;
    assign dn_first  = first_q;
    assign dn_data   = data_q;
endmodule

// File: rtl/chain_rsp_merger.sv
// Response path: merges the local and downstream response streams, ORs the
// stage error flags into the footer and corrects the checksum to match.
// Assumes the two sources never overlap; the local one wins if they do.
module chain_rsp_merger #(
    parameter int BYTE_W    = chain_fwd_pkg::BYTE_W,
    parameter int FRAME_LEN = chain_fwd_pkg::FRAME_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dn_valid,
    input  logic              dn_first,
    input  logic [BYTE_W-1:0] dn_data,
    input  logic              loc_valid,
    input  logic              loc_first,
    input  logic [BYTE_W-1:0] loc_data,
    input  logic [BYTE_W-1:0] stage_flags,
    output logic              up_valid,
    output logic              up_first,
    output logic [BYTE_W-1:0] up_data
);
    localparam int POS_W      = $clog2(FRAME_LEN + 1);
    localparam int FOOTER_POS = FRAME_LEN - 2;
    localparam int CSUM_POS   = FRAME_LEN - 1;

    logic              m_valid;
    logic              m_first;
    logic [BYTE_W-1:0] m_data;
    logic [POS_W-1:0]  pos;
    logic              accept;
    logic [BYTE_W-1:0] byte_out;
    logic [BYTE_W-1:0] adj_q;

    // Source selection, local response has priority.
    always_comb begin
        m_valid = loc_valid || dn_valid;
        m_first = loc_valid ? loc_first : dn_first;
        m_data  = loc_valid ? loc_data  : dn_data;
    end

    chain_frame_tracker #(
        .FRAME_LEN (FRAME_LEN),
        .POS_W     (POS_W)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (m_valid),
        .beat_first (m_first),
        .pos        (pos),
        .accept     (accept)
    );

    // Footer merge and checksum correction per byte position.
    always_comb begin
        byte_out = m_data;
        if (pos == POS_W'(FOOTER_POS)) begin
            byte_out = m_data | stage_flags;
        end else if (pos == POS_W'(CSUM_POS)) begin
            byte_out = m_data + adj_q;
        end
    end

    // Checksum correction: cleared at the header, set at the footer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adj_q <= '0;
        end else if (accept && (pos == '0)) begin
            adj_q <= '0;
        end else if (accept && (pos == POS_W'(FOOTER_POS))) begin
            adj_q <= m_data - byte_out;
        end
    end

    // Output register stage toward upstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_valid <= 1'b0;
            up_first <= 1'b0;
            up_data  <= '0;
        end else begin
            up_valid <= accept;
            up_first <= accept && m_first;
            up_data  <= byte_out;
        end
    end
endmodule

// File: rtl/chain_frame_forwarder.sv
// Top level of one daisy-chain stage: routes register requests by hop count
// and merges responses back toward the host. Assumes one transaction in
// flight, so neither direction needs backpressure.
module chain_frame_forwarder import chain_fwd_pkg::*; #(
    parameter int BYTE_W    = chain_fwd_pkg::BYTE_W,
    parameter int FRAME_LEN = chain_fwd_pkg::FRAME_BYTES,
    parameter int HOP_LO    = chain_fwd_pkg::HOP_LO,
    parameter int HOP_W     = chain_fwd_pkg::HOP_W,
    parameter int LOCAL_HOP = chain_fwd_pkg::LOCAL_HOP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_req_valid,
    input  logic              up_req_first,
    input  logic [BYTE_W-1:0] up_req_data,
    output logic              loc_req_valid,
    output logic              loc_req_first,
    output logic [BYTE_W-1:0] loc_req_data,
    output logic              dn_req_valid,
    output logic              dn_req_first,
    output logic [BYTE_W-1:0] dn_req_data,
    input  logic              dn_rsp_valid,
    input  logic              dn_rsp_first,
    input  logic [BYTE_W-1:0] dn_rsp_data,
    input  logic              loc_rsp_valid,
    input  logic              loc_rsp_first,
    input  logic [BYTE_W-1:0] loc_rsp_data,
    input  logic [BYTE_W-1:0] stage_flags,
    output logic              up_rsp_valid,
    output logic              up_rsp_first,
    output logic [BYTE_W-1:0] up_rsp_data
);
    chain_req_router #(
        .BYTE_W    (BYTE_W),
        .FRAME_LEN (FRAME_LEN),
        .HOP_LO    (HOP_LO),
        .HOP_W     (HOP_W),
        .LOCAL_HOP (LOCAL_HOP)
    ) u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (up_req_valid),
        .in_first  (up_req_first),
        .in_data   (up_req_data),
        .loc_valid (loc_req_valid),
        .loc_first (loc_req_first),
        .loc_data  (loc_req_data),
        .dn_valid  (dn_req_valid),
        .dn_first  (dn_req_first),
        .dn_data   (dn_req_data)
    );

    chain_rsp_merger #(
        .BYTE_W    (BYTE_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .dn_valid    (dn_rsp_valid),
        .dn_first    (dn_rsp_first),
        .dn_data     (dn_rsp_data),
        .loc_valid   (loc_rsp_valid),
        .loc_first   (loc_rsp_first),
        .loc_data    (loc_rsp_data),
        .stage_flags (stage_flags),
        .up_valid    (up_rsp_valid),
        .up_first    (up_rsp_first),
        .up_data     (up_rsp_data)
    );
endmodule

// File: rtl/chain_fwd_checker.sv
// Property checker for the frame forwarder, bound to every instance.
// Assumes headers carry the first flag and response sources never overlap.
module chain_fwd_checker #(
    parameter int BYTE_W = 8,
    parameter int HOP_LO = 4,
    parameter int HOP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_req_valid,
    input logic              up_req_first,
    input logic [BYTE_W-1:0] up_req_data,
    input logic              loc_req_valid,
    input logic              loc_req_first,
    input logic [BYTE_W-1:0] loc_req_data,
    input logic              dn_req_valid,
    input logic              dn_req_first,
    input logic [BYTE_W-1:0] dn_req_data,
    input logic              dn_rsp_valid,
    input logic              loc_rsp_valid,
    input logic              up_rsp_valid
);
    // A request byte never goes to both destinations (R1, R2).
    assert_one_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_req_valid, dn_req_valid}));

    // Hop count 1 delivers the header locally, unmodified.
    assert_local_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_first && (up_req_data[HOP_LO +: HOP_W] == HOP_W'(1)))
        |=> (loc_req_valid && loc_req_first && (loc_req_data == $past(up_req_data))));

    // Hop count of two or more leaves downstream lowered by one.
    assert_hop_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_first && (up_req_data[HOP_LO +: HOP_W] > HOP_W'(1)))
        |=> (dn_req_valid && dn_req_first &&
             (dn_req_data[HOP_LO +: HOP_W] == HOP_W'($past(up_req_data[HOP_LO +: HOP_W]) - 1'b1))));

    // Hop count 0 passes downstream untouched.
    assert_zero_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req_valid && up_req_first && (up_req_data[HOP_LO +: HOP_W] == '0))
        |=> (dn_req_valid && (dn_req_data == $past(up_req_data))));

    // No request input byte, no request output byte a cycle later.
    assert_req_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !up_req_valid |=> (!loc_req_valid && !dn_req_valid));

    // No response input byte, no upstream response byte a cycle later.
    assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_rsp_valid && !loc_rsp_valid) |=> !up_rsp_valid);
endmodule

bind chain_frame_forwarder chain_fwd_checker #(
    .BYTE_W (BYTE_W),
    .HOP_LO (HOP_LO),
    .HOP_W  (HOP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .up_req_valid  (up_req_valid),
    .up_req_first  (up_req_first),
    .up_req_data   (up_req_data),
    .loc_req_valid (loc_req_valid),
    .loc_req_first (loc_req_first),
    .loc_req_data  (loc_req_data),
    .dn_req_valid  (dn_req_valid),
    .dn_req_first  (dn_req_first),
    .dn_req_data   (dn_req_data),
    .dn_rsp_valid  (dn_rsp_valid),
    .loc_rsp_valid (loc_rsp_valid),
    .up_rsp_valid  (up_rsp_valid)
);

// File: tb/test_chain_frame_forwarder.sv
// Bench: behavioural reference model with expected-byte queues, compared
// against every output byte on every clock.
module test_chain_frame_forwarder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_req_valid = 1'b0, up_req_first = 1'b0;
    logic [7:0] up_req_data = '0;
    logic       loc_req_valid, loc_req_first;
    logic [7:0] loc_req_data;
    logic       dn_req_valid, dn_req_first;
    logic [7:0] dn_req_data;
    logic       dn_rsp_valid = 1'b0, dn_rsp_first = 1'b0;
    logic [7:0] dn_rsp_data = '0;
    logic       loc_rsp_valid = 1'b0, loc_rsp_first = 1'b0;
    logic [7:0] loc_rsp_data = '0;
    logic [7:0] stage_flags = '0;
    logic       up_rsp_valid, up_rsp_first;
    logic [7:0] up_rsp_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;
    string cur_req = "R10";
    logic [8:0] q_loc[$], q_dn[$], q_up[$];
    int t_loc[$], t_dn[$], t_up[$];
    logic [8:0] e;
    int te;

    always #2.5 clk = ~clk;

    chain_frame_forwarder i_chain_frame_forwarder (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", cyc, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Compare every output byte against the model queues (value and cycle).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (loc_req_valid) begin
                if (q_loc.size() == 0) check(1'b0, {cur_req, " unexpected local byte"}, {loc_req_first, loc_req_data}, 0);
                else begin
                    e = q_loc.pop_front(); te = t_loc.pop_front();
                    check({loc_req_first, loc_req_data} == e, {cur_req, " local byte"}, {loc_req_first, loc_req_data}, e);
                    check(cyc == te, "R5 local latency", cyc, te);
                end
            end
            if (dn_req_valid) begin
                if (q_dn.size() == 0) check(1'b0, {cur_req, " unexpected downstream byte"}, {dn_req_first, dn_req_data}, 0);
                else begin
                    e = q_dn.pop_front(); te = t_dn.pop_front();
                    check({dn_req_first, dn_req_data} == e, {cur_req, " downstream byte"}, {dn_req_first, dn_req_data}, e);
                    check(cyc == te, "R5 downstream latency", cyc, te);
                end
            end
            if (up_rsp_valid) begin
                if (q_up.size() == 0) check(1'b0, {cur_req, " unexpected response byte"}, {up_rsp_first, up_rsp_data}, 0);
                else begin
                    e = q_up.pop_front(); te = t_up.pop_front();
                    check({up_rsp_first, up_rsp_data} == e, {cur_req, " response byte"}, {up_rsp_first, up_rsp_data}, e);
                    check(cyc == te, "R5 response latency", cyc, te);
                end
            end
        end
    end

    // Send n bytes of a request; model: hop 1 local, hop>=2 lowered, hop 0 kept,
    // checksum shifted by the change in byte sum (R4).
    task automatic send_req(input logic [7:0] hdr, input logic [7:0] seed, input int gap,
                            input logic [7:0] ck_err, input int n);
        logic [7:0] b [11];
        logic [7:0] o [11];
        logic [7:0] s_in, s_out;
        s_in = '0;
        for (int i = 0; i < 10; i++) begin
            b[i] = (i == 0) ? hdr : 8'(seed + i * 29);
            s_in += b[i];
        end
        b[10] = ~s_in + ck_err;
        o = b;
        if (hdr[7:4] >= 4'd2) o[0] = hdr - 8'h10;
        s_out = '0;
        for (int i = 0; i < 10; i++) s_out += o[i];
        o[10] = b[10] + (s_in - s_out);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            up_req_valid = 1'b1;
            up_req_first = (i == 0);
            up_req_data  = b[i];
            if (hdr[7:4] == 4'd1) begin
                q_loc.push_back({(i == 0) ? 1'b1 : 1'b0, o[i]}); t_loc.push_back(cyc + 1);
            end else begin
                q_dn.push_back({(i == 0) ? 1'b1 : 1'b0, o[i]}); t_dn.push_back(cyc + 1);
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                up_req_valid = 1'b0; up_req_first = 1'b0;
            end
        end
        @(negedge clk);
        up_req_valid = 1'b0; up_req_first = 1'b0; up_req_data = '0;
    endtask

    // Send a full response from one source; model footer OR and checksum shift.
    task automatic send_rsp(input bit from_local, input logic [7:0] hdr, input logic [7:0] seed,
                            input logic [7:0] footer, input logic [7:0] flags, input int gap);
        logic [7:0] b [11];
        logic [7:0] o [11];
        logic [7:0] s_in, s_out;
        stage_flags = flags;
        s_in = '0;
        for (int i = 0; i < 10; i++) begin
            b[i] = (i == 0) ? hdr : (i == 9) ? footer : 8'(seed + i * 17);
            s_in += b[i];
        end
        b[10] = ~s_in;
        o = b;
        o[9] = footer | flags;
        s_out = '0;
        for (int i = 0; i < 10; i++) s_out += o[i];
        o[10] = b[10] + (s_in - s_out);
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            if (from_local) begin
                loc_rsp_valid = 1'b1; loc_rsp_first = (i == 0); loc_rsp_data = b[i];
            end else begin
                dn_rsp_valid = 1'b1; dn_rsp_first = (i == 0); dn_rsp_data = b[i];
            end
            q_up.push_back({(i == 0) ? 1'b1 : 1'b0, o[i]}); t_up.push_back(cyc + 1);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                loc_rsp_valid = 1'b0; dn_rsp_valid = 1'b0;
                loc_rsp_first = 1'b0; dn_rsp_first = 1'b0;
            end
        end
        @(negedge clk);
        loc_rsp_valid = 1'b0; dn_rsp_valid = 1'b0;
        loc_rsp_first = 1'b0; dn_rsp_first = 1'b0;
    endtask

    initial begin
        // R10: outputs quiet during and right after reset.
        repeat (3) @(negedge clk);
        check(!loc_req_valid && !dn_req_valid && !up_rsp_valid, "R10 valids in reset",
              {loc_req_valid, dn_req_valid, up_rsp_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!loc_req_valid && !dn_req_valid && !up_rsp_valid, "R10 valids after reset",
              {loc_req_valid, dn_req_valid, up_rsp_valid}, 0);

        cur_req = "R1";  send_req(8'h1A, 8'h33, 0, 8'h00, 11);
        cur_req = "R2";  send_req(8'h35, 8'h71, 0, 8'h00, 11);
        cur_req = "R2";  send_req(8'hF3, 8'h05, 2, 8'h00, 11);
        cur_req = "R3";  send_req(8'h07, 8'hC2, 0, 8'h00, 11);
        cur_req = "R4";  send_req(8'h42, 8'h19, 0, 8'h05, 11);
        cur_req = "R4";  send_req(8'h1F, 8'h88, 0, 8'h3C, 11);
        cur_req = "R5";  send_req(8'h2C, 8'hE0, 3, 8'h00, 11);

        // R6: stray bytes with no open frame produce nothing.
        cur_req = "R6";
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            up_req_valid = 1'b1; up_req_first = 1'b0; up_req_data = 8'h11 + 8'(k);
        end
        @(negedge clk);
        up_req_valid = 1'b0; up_req_data = '0;
        check(!loc_req_valid && !dn_req_valid, "R6 stray byte output", {loc_req_valid, dn_req_valid}, 0);
        @(negedge clk);
        check(!loc_req_valid && !dn_req_valid, "R6 stray byte output", {loc_req_valid, dn_req_valid}, 0);

        // R7: a new header mid-frame restarts with its own route.
        cur_req = "R7";  send_req(8'h51, 8'h44, 0, 8'h00, 4);
        cur_req = "R7";  send_req(8'h13, 8'h9A, 0, 8'h00, 11);

        cur_req = "R8";  send_rsp(1'b0, 8'h20, 8'h61, 8'h01, 8'h0C, 0);
        cur_req = "R8";  send_rsp(1'b0, 8'h00, 8'h17, 8'h10, 8'h00, 1);
        cur_req = "R9";  send_rsp(1'b1, 8'h10, 8'hB4, 8'h02, 8'h18, 0);

        repeat (4) @(negedge clk);
        check(q_loc.size() == 0, "R1 all local bytes delivered", q_loc.size(), 0);
        check(q_dn.size() == 0, "R2 all downstream bytes delivered", q_dn.size(), 0);
        check(q_up.size() == 0, "R9 all response bytes delivered", q_up.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule